// File: doc/BRIEF.md
# Adaptive Peak-Level Tracker and Data Slicer

This block sits after the receive filter of a binary FM baseband receiver. It takes a signed, oversampled signal and follows two levels: the positive peak and the negative peak. Their midpoint is the decision level. One data bit is sliced for each bit strobe from the recovered clock, so the decision follows changes in both signal amplitude and DC offset.

Two controls set how the peak levels are followed: a level-acquire input and an active-low hold input. A fresh acquire first pulls both levels quickly toward half the incoming signal for one bit. The levels then follow peaks fast while acquire stays high. After acquire is released, the levels average slowly at the bit centres. When hold is also low, both levels decay slowly toward zero. A receive power-save input stops all tracking and forces the data output low.

Top module: `peak_level_slicer`

## Requirements
- R1: On the first cycle where `lvl_acq` is 1 after being 0 (or after reset), clamp mode starts. In clamp mode each valid sample moves both estimates by floor((x·2^(FRAC_W-1) − est) / 2^CLAMP_SH), which is toward half the sample.
- R2: Clamp mode lasts up to and including the first cycle with `bit_stb` high. After that, while `lvl_acq` stays 1, the block is in fast peak mode.
- R3: In fast peak mode, a valid sample x (scaled by 2^FRAC_W) above the positive estimate raises it by floor(error / 2^FAST_SH). A sample below the negative estimate lowers it by the same rule. No other sample changes either estimate.
- R4: `hold_n` has no effect while `lvl_acq` is 1.
- R5: With `lvl_acq`=0 and `hold_n`=1, estimates change only on `bit_stb`. The sample that is sliced above the threshold moves the positive estimate by floor(error / 2^AVG_SH); any other sample moves the negative estimate by the same rule.
- R6: With `lvl_acq`=0 and `hold_n`=0, estimates change only on `bit_stb`, each becoming est − floor(est / 2^LEAK_SH).
- R7: `thresh` always equals `pk_pos + pk_neg`. It is the mean of the two estimates with FRAC_W+1 fraction bits.
- R8: On `bit_stb`, the decision sample is the current sample if `sample_vld` is high; otherwise it is the last valid sample. The bit is 0 if sample·2^(FRAC_W+1) > `thresh`, and 1 if it is equal or lower.
- R9: `rx_bit` takes the decision in the cycle after the strobe and holds it until the cycle after the next strobe.
- R10: While `rx_psave` is 1, `rx_bit` is 0 in the same cycle, the estimates do not change, and the stored bit is cleared.
- R11: After reset both estimates, the threshold and `rx_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | SAMPLE_W | Signed filtered sample, zero is the bias level |
| sample_vld | input | 1 | Sample valid |
| bit_stb | input | 1 | One-cycle recovered bit strobe |
| lvl_acq | input | 1 | Level acquire control |
| hold_n | input | 1 | Active-low hold control |
| rx_psave | input | 1 | Receive power-save |
| pk_pos | output | SAMPLE_W+FRAC_W | Positive peak estimate, FRAC_W fraction bits |
| pk_neg | output | SAMPLE_W+FRAC_W | Negative peak estimate, FRAC_W fraction bits |
| thresh | output | SAMPLE_W+FRAC_W+1 | Decision threshold, FRAC_W+1 fraction bits |
| rx_bit | output | 1 | Sliced data bit |

## Verification
The bench keeps SAMPLE_W=12, FRAC_W=6 and the clamp, fast and averaging shifts at their defaults. With these values, the clamp and fast-mode steps are small integers that can be worked out by hand. LEAK_SH is reduced to 4, so the decay in hold mode appears within a few strobes instead of thousands. The bench also reaches the equality case of the slicer by striking a zero sample against the zero threshold left by reset.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [1:0] {
    M_CLAMP = 2'd0,
    M_FAST  = 2'd1,
    M_AVG   = 2'd2,
    M_HOLD  = 2'd3
  } lvl_mode_e;
endpackage

// File: rtl/pls_mode_ctrl.sv
module pls_mode_ctrl
  import pls_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_acq,
  input  logic      hold_n,
  input  logic      bit_stb,
  output lvl_mode_e mode,
  output logic      acq_rise
);
  logic acq_q;
  logic clamp_q;
  logic in_clamp;

  assign acq_rise = lvl_acq & ~acq_q;
  assign in_clamp = lvl_acq & (acq_rise | clamp_q);

  always_comb begin
    if (in_clamp)     mode = M_CLAMP;
    else if (lvl_acq) mode = M_FAST;
    else if (hold_n)  mode = M_AVG;
    else              mode = M_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q   <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      acq_q   <= lvl_acq;
      clamp_q <= in_clamp & ~bit_stb;
    end
  end

  p_rise_clamps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acq_rise |-> mode == M_CLAMP);
  p_clamp_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CLAMP && bit_stb) |=> mode != M_CLAMP);
  p_hold_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_acq |-> (mode == M_CLAMP || mode == M_FAST));
endmodule

// File: rtl/pls_peak_track.sv
module pls_peak_track
  import pls_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FRAC_W   = 6,
  parameter bit IS_POS   = 1'b1,
  parameter int CLAMP_SH = 2,
  parameter int FAST_SH  = 2,
  parameter int AVG_SH   = 6,
  parameter int LEAK_SH  = 11
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               run,
  input  lvl_mode_e                          mode,
  input  logic signed [SAMPLE_W-1:0]         sample,
  input  logic                               sample_vld,
  input  logic                               bit_stb,
  input  logic signed [SAMPLE_W-1:0]         dec_x,
  input  logic                               dec_above,
  output logic signed [SAMPLE_W+FRAC_W-1:0]  est
);
  localparam int EW = SAMPLE_W + FRAC_W;
  localparam int DW = EW + 2;

  function automatic logic signed [DW-1:0] approach(
      input logic signed [DW-1:0] cur, input logic signed [DW-1:0] tgt, input int sh);
    return cur + ((tgt - cur) >>> sh);
  endfunction

  function automatic logic signed [DW-1:0] leak(input logic signed [DW-1:0] cur, input int sh);
    return cur - (cur >>> sh);
  endfunction

  logic signed [DW-1:0] est_w, x_w, d_w;
  logic signed [EW-1:0] est_nxt;
  logic                 beyond;
  logic                 upd_evt;

  assign est_w  = DW'(est);
  assign x_w    = DW'(sample) <<< FRAC_W;
  assign d_w    = DW'(dec_x) <<< FRAC_W;
  assign beyond = IS_POS ? (x_w > est_w) : (x_w < est_w);

  always_comb begin
    est_nxt = est;
    unique case (mode)
      M_CLAMP: if (sample_vld) est_nxt = EW'(approach(est_w, x_w >>> 1, CLAMP_SH));
      M_FAST:  if (sample_vld && beyond) est_nxt = EW'(approach(est_w, x_w, FAST_SH));
      M_AVG:   if (bit_stb && (dec_above == IS_POS)) est_nxt = EW'(approach(est_w, d_w, AVG_SH));
      M_HOLD:  if (bit_stb) est_nxt = EW'(leak(est_w, LEAK_SH));
      default: est_nxt = est;
    endcase
  end

  assign upd_evt = run && (est_nxt != est);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       est <= '0;
    else if (upd_evt) est <= est_nxt;
  end

  generate
    if (IS_POS) begin : g_pos
      p_fast_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == M_FAST) |=> est >= $past(est));
    end else begin : g_neg
      p_fast_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == M_FAST) |=> est <= $past(est));
    end
  endgenerate

  p_avg_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == M_AVG && !bit_stb) |=> $stable(est));
  p_hold_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == M_HOLD && !bit_stb) |=> $stable(est));
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(est));
endmodule

// File: rtl/pls_decide.sv
module pls_decide #(
  parameter int SAMPLE_W = 12,
  parameter int FRAC_W   = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              psave,
  input  logic signed [SAMPLE_W-1:0]        sample,
  input  logic                              sample_vld,
  input  logic                              bit_stb,
  input  logic signed [SAMPLE_W+FRAC_W:0]   thresh,
  output logic signed [SAMPLE_W-1:0]        dec_x,
  output logic                              dec_above,
  output logic                              rx_bit
);
  localparam int DW = SAMPLE_W + FRAC_W + 2;

  logic signed [SAMPLE_W-1:0] last_q;
  logic                       bit_q;

  assign dec_x     = sample_vld ? sample : last_q;
  assign dec_above = (DW'(dec_x) <<< (FRAC_W + 1)) > DW'(thresh);
  assign rx_bit    = bit_q & ~psave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      if (sample_vld) last_q <= sample;
      if (psave)        bit_q <= 1'b0;
      else if (bit_stb) bit_q <= ~dec_above;
    end
  end

  p_bit_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !psave) |=> $stable(bit_q));
  p_psave_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    psave |-> !rx_bit);
  p_psave_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    psave |=> !bit_q);
endmodule

// File: rtl/peak_level_slicer.sv
module peak_level_slicer
  import pls_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FRAC_W   = 6,
  parameter int CLAMP_SH = 2,
  parameter int FAST_SH  = 2,
  parameter int AVG_SH   = 6,
  parameter int LEAK_SH  = 11
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic signed [SAMPLE_W-1:0]         sample_in,
  input  logic                               sample_vld,
  input  logic                               bit_stb,
  input  logic                               lvl_acq,
  input  logic                               hold_n,
  input  logic                               rx_psave,
  output logic signed [SAMPLE_W+FRAC_W-1:0]  pk_pos,
  output logic signed [SAMPLE_W+FRAC_W-1:0]  pk_neg,
  output logic signed [SAMPLE_W+FRAC_W:0]    thresh,
  output logic                               rx_bit
);
  localparam int EW = SAMPLE_W + FRAC_W;

  function automatic logic signed [EW:0] mid_sum(
      input logic signed [EW-1:0] a, input logic signed [EW-1:0] b);
    return {a[EW-1], a} + {b[EW-1], b};
  endfunction

  lvl_mode_e                  mode;
  logic                       acq_rise;
  logic signed [SAMPLE_W-1:0] dec_x;
  logic                       dec_above;
  logic                       run;

  assign run    = ~rx_psave;
  assign thresh = mid_sum(pk_pos, pk_neg);

  pls_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .lvl_acq(lvl_acq), .hold_n(hold_n),
    .bit_stb(bit_stb), .mode(mode), .acq_rise(acq_rise)
  );

  for (genvar g = 0; g < 2; g++) begin : g_trk
    logic signed [EW-1:0] est;
    pls_peak_track #(
      .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .IS_POS(g == 0),
      .CLAMP_SH(CLAMP_SH), .FAST_SH(FAST_SH), .AVG_SH(AVG_SH), .LEAK_SH(LEAK_SH)
    ) u_trk (
      .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
      .sample(sample_in), .sample_vld(sample_vld), .bit_stb(bit_stb),
      .dec_x(dec_x), .dec_above(dec_above), .est(est)
    );
  end

  assign pk_pos = g_trk[0].est;
  assign pk_neg = g_trk[1].est;

  pls_decide #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .psave(rx_psave), .sample(sample_in),
    .sample_vld(sample_vld), .bit_stb(bit_stb), .thresh(thresh),
    .dec_x(dec_x), .dec_above(dec_above), .rx_bit(rx_bit)
  );

  p_clamp_equal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_rise && !rx_psave && pk_pos == pk_neg) |=> pk_pos == pk_neg);
  p_psave_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_psave |=> ($stable(pk_pos) && $stable(pk_neg)));
endmodule

// File: tb/peak_level_slicer_tb.sv
`timescale 1ns/1ps
module peak_level_slicer_tb;
  localparam int W = 12, F = 6, CS = 2, FS = 2, AS = 6, LS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic signed [W-1:0] sample_in = '0;
  logic sample_vld = 0, bit_stb = 0, lvl_acq = 0, hold_n = 1, rx_psave = 0;
  logic signed [W+F-1:0] pk_pos, pk_neg;
  logic signed [W+F:0] thresh;
  logic rx_bit;

  int n_chk = 0, n_fail = 0;
  int m_pos = 0, m_neg = 0, m_last = 0, m_bit = 0, m_acq = 0, m_clamp = 0, m_ps = 0;

  always #4 clk = ~clk;

  peak_level_slicer #(.SAMPLE_W(W), .FRAC_W(F), .CLAMP_SH(CS), .FAST_SH(FS),
                      .AVG_SH(AS), .LEAK_SH(LS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .sample_vld(sample_vld),
    .bit_stb(bit_stb), .lvl_acq(lvl_acq), .hold_n(hold_n), .rx_psave(rx_psave),
    .pk_pos(pk_pos), .pk_neg(pk_neg), .thresh(thresh), .rx_bit(rx_bit));

  function automatic int fdiv(int a, int k);
    int d = 1 << k;
    if (a >= 0) return a / d;
    return -((-a + d - 1) / d);
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_model(string tag);
    chk({tag, " pk_pos"}, int'(pk_pos), m_pos);
    chk({tag, " pk_neg"}, int'(pk_neg), m_neg);
    chk({tag, " R7 thresh"}, int'(thresh), m_pos + m_neg);
    chk({tag, " rx_bit"}, int'(rx_bit), m_ps ? 0 : m_bit);
  endtask

  // one clock of stimulus; the bench model follows the requirements
  task automatic drive(int x, bit v, bit s, bit acq, bit hn, bit ps);
    int dec, np, nn;
    bit rise, clampm, above;
    @(negedge clk);
    sample_in = W'(x); sample_vld = v; bit_stb = s; lvl_acq = acq; hold_n = hn; rx_psave = ps;
    rise   = acq && (m_acq == 0);
    clampm = acq && (rise || m_clamp != 0);
    dec    = v ? x : m_last;
    above  = (dec * (1 << (F + 1))) > (m_pos + m_neg);
    np = m_pos; nn = m_neg;
    if (!ps) begin
      if (clampm) begin
        if (v) begin
          np = m_pos + fdiv(x * (1 << (F - 1)) - m_pos, CS);
          nn = m_neg + fdiv(x * (1 << (F - 1)) - m_neg, CS);
        end
      end else if (acq) begin
        if (v && x * (1 << F) > m_pos) np = m_pos + fdiv(x * (1 << F) - m_pos, FS);
        if (v && x * (1 << F) < m_neg) nn = m_neg + fdiv(x * (1 << F) - m_neg, FS);
      end else if (hn) begin
        if (s && above)  np = m_pos + fdiv(dec * (1 << F) - m_pos, AS);
        if (s && !above) nn = m_neg + fdiv(dec * (1 << F) - m_neg, AS);
      end else if (s) begin
        np = m_pos - fdiv(m_pos, LS);
        nn = m_neg - fdiv(m_neg, LS);
      end
    end
    @(posedge clk);
    m_pos = np; m_neg = nn;
    if (ps) m_bit = 0; else if (s) m_bit = above ? 0 : 1;
    if (v) m_last = x;
    m_acq = acq; m_clamp = (clampm && !s) ? 1 : 0; m_ps = ps;
    #2;
  endtask

  task automatic t_reset();
    chk("R11 pk_pos", int'(pk_pos), 0);
    chk("R11 pk_neg", int'(pk_neg), 0);
    chk("R11 thresh", int'(thresh), 0);
    chk("R11 rx_bit", int'(rx_bit), 0);
    drive(0, 1, 1, 0, 0, 0);              // sample equal to threshold
    chk("R8 equal gives 1", int'(rx_bit), 1);
  endtask

  task automatic t_clamp();
    drive(400, 1, 0, 1, 1, 0);
    chk("R1 pos first step", int'(pk_pos), 3200);
    chk("R1 neg first step", int'(pk_neg), 3200);
    drive(400, 1, 0, 1, 1, 0);
    chk("R1 second step", int'(pk_pos), 5600);
    drive(400, 1, 1, 1, 1, 0);            // strobe still in clamp
    chk("R2 clamp on strobe", int'(pk_pos), 7400);
    drive(-300, 1, 0, 1, 1, 0);           // now fast
    chk("R2 pos kept in fast", int'(pk_pos), 7400);
    chk("R2 neg fast step", int'(pk_neg), 750);
  endtask

  task automatic t_fast();
    drive(600, 1, 0, 1, 0, 0);
    chk("R4 hold_n ignored", int'(pk_pos), 15150);
    drive(100, 1, 0, 1, 0, 0);
    chk("R3 inner sample pos", int'(pk_pos), 15150);
    chk("R3 inner sample neg", int'(pk_neg), 750);
    drive(-500, 0, 0, 1, 1, 0);
    chk("R3 invalid ignored", int'(pk_neg), 750);
    for (int i = 0; i < 6; i++) drive((i % 2) ? -700 : 700, 1, (i == 3), 1, (i % 3) != 0, 0);
    chk_model("R3 R4 run");
  endtask

  task automatic t_avg();
    int p0, n0;
    p0 = int'(pk_pos); n0 = int'(pk_neg);
    for (int i = 0; i < 4; i++) drive(800, 1, 0, 0, 1, 0);
    chk("R5 no strobe pos", int'(pk_pos), p0);
    chk("R5 no strobe neg", int'(pk_neg), n0);
    drive(700, 1, 1, 0, 1, 0);
    chk_model("R5 strobe high");
    chk("R8 above gives 0", int'(rx_bit), 0);
    drive(-700, 1, 0, 0, 1, 0);
    chk("R9 held between strobes", int'(rx_bit), 0);
    drive(0, 0, 1, 0, 1, 0);              // uses last valid -700
    chk("R8 last valid sample", int'(rx_bit), 1);
    chk_model("R5 strobe low");
    for (int i = 0; i < 5; i++) drive(i * 150 - 300, 1, 1, 0, 1, 0);
    chk_model("R5 R8 sequence");
  endtask

  task automatic t_hold();
    int p0;
    p0 = int'(pk_pos);
    drive(900, 1, 0, 0, 0, 0);
    chk("R6 no strobe", int'(pk_pos), p0);
    for (int i = 0; i < 3; i++) drive(-900, 1, 1, 0, 0, 0);
    chk_model("R6 leak");
  endtask

  task automatic t_psave();
    int p0, n0;
    drive(800, 1, 1, 0, 1, 0);            // stored bit becomes 0 or 1
    drive(-800, 1, 1, 0, 1, 0);
    chk("R8 below gives 1", int'(rx_bit), 1);
    p0 = int'(pk_pos); n0 = int'(pk_neg);
    drive(-900, 1, 1, 0, 1, 1);
    chk("R10 bit forced 0", int'(rx_bit), 0);
    drive(900, 1, 0, 1, 1, 1);
    drive(900, 1, 1, 1, 1, 1);
    chk("R10 pos frozen", int'(pk_pos), p0);
    chk("R10 neg frozen", int'(pk_neg), n0);
    drive(-900, 1, 0, 0, 0, 0);
    chk("R10 bit cleared", int'(rx_bit), 0);
    drive(-200, 1, 0, 1, 1, 0);           // new acquire, negative input
    drive(-200, 1, 1, 1, 1, 0);
    chk_model("R1 R2 negative clamp");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    t_reset();
    t_clamp();
    t_fast();
    t_avg();
    t_hold();
    t_psave();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule